// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block is the sending side of a slave-mode stereo serial audio port. It never generates the serial timing itself. An external master supplies the bit clock and the word select. The block puts out one left/right sample pair per frame, with up to 18 bits per sample, and drives one data bit per bit-clock period. Both serial inputs are oversampled on the block's own system clock. A selectable bit-clock edge sets when each new data bit is launched.

A three-bit format code selects one of two framings: least-significant-bit-justified or I2S. The same code selects a 16-bit word in a 32-clock frame, a 16-bit word in a 64-clock frame, or an 18-bit word in a 64-clock frame. Bit periods that the word does not fill are driven to zero. The length code for a 48-clock frame cannot be sent: while it is selected the data stays at zero and an error flag is raised.

The data pin is high-impedance whenever the output enable is low, so the line can be shared with other senders. The port also passes an active-high overload indication from upstream logic out as an active-low flag.

Top module: `audio_ser_tx`

## Requirements
- R1: With format bit 2 = 0 (LSB-justified), the left slot is the one where word select is high. The word fills the last W bit periods of each slot, where W is the word length. Its LSB goes out in the final period before word select changes.
- R2: With format bit 2 = 1 (I2S), the left slot is the one where word select is low. The MSB goes out in the second bit period after word select changes. In the 32-clock framing, the LSB goes out in the first period of the following slot.
- R3: Words are sent MSB first. An 18-bit word is the whole sample. A 16-bit word is sample bits 17 down to 2.
- R4: Format bits 1:0 select the length: 00 = 16-bit word in a 32-clock frame (16 periods per slot), 01 = 16-bit word in a 64-clock frame (32 per slot), 11 = 18-bit word in a 64-clock frame (32 per slot).
- R5: Every bit period that the word does not occupy carries 0.
- R6: With edge select 0, the data changes after a falling bit-clock edge; with 1, after a rising edge. The new bit is at the pin within 4 system clocks of that edge and holds until the next launch edge.
- R7: While the output enable is low, the data output is high-impedance.
- R8: A new left/right pair is taken from the sample inputs when the left slot begins. Changes on the sample inputs later in that frame do not alter the data sent in it.
- R9: While format bits 1:0 = 10, the data output is 0. The error flag is high one system clock after that code is applied and low one clock after a valid code returns.
- R10: The active-low overload output follows the inverse of the overload input one system clock later.
- R11: After reset the data output stays 0 until word select has changed once. The first launch edge only records the word select level.
- R12: In reset, the data output is 0, the error flag is 0 and the overload output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Format code: bit 2 selects framing, bits 1:0 select length |
| edge_sel_i | input | 1 | Launch edge select: 0 falling, 1 rising |
| en_i | input | 1 | Data output enable, active high |
| bck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select |
| left_i | input | 18 | Left sample |
| right_i | input | 18 | Right sample |
| ovl_i | input | 1 | Overload indication from upstream, active high |
| sd_o | output | 1 | Serial data, high-impedance while disabled |
| ovl_n_o | output | 1 | Overload flag, active low |
| fmt_err_o | output | 1 | High while an unsupported format code is applied |

## Verification
A launch edge reaches the pin through four system-clock registers: two synchronizer stages, the slot tracker and the output register. The new bit is therefore present by the fourth clock after the edge. The bench drives the serial inputs on falling system-clock edges. It samples the data five and eleven clocks after each launch edge, which is before and after the opposite bit-clock edge, so an output launched on the wrong edge disagrees at one of the two samples. The error flag and the overload flag are registered once and are read two clocks after their stimulus. The enable acts combinationally and is read in the same bit period it changes.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;

    typedef enum logic [1:0] {
        LEN_S16_NARROW = 2'b00,
        LEN_S16_WIDE   = 2'b01,
        LEN_UNSUPP     = 2'b10,
        LEN_S18_WIDE   = 2'b11
    } len_code_e;

    typedef struct packed {
        logic i2s;
        logic valid;
        logic long_word;
        logic wide_slot;
    } fmt_dec_t;

    function automatic fmt_dec_t decode_fmt(input logic [2:0] code);
        fmt_dec_t d;
        d.i2s       = code[2];
        d.valid     = 1'b1;
        d.long_word = 1'b0;
        d.wide_slot = 1'b0;
        unique case (len_code_e'(code[1:0]))
            LEN_S16_NARROW: d.wide_slot = 1'b0;
            LEN_S16_WIDE:   d.wide_slot = 1'b1;
            LEN_S18_WIDE: begin
                d.wide_slot = 1'b1;
                d.long_word = 1'b1;
            end
            default:        d.valid = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/audio_ser_tx_sync.sv
module audio_ser_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    input  logic edge_sel_i,
    output logic launch_o,
    output logic ws_o
);

    typedef struct packed {
        logic [STAGES-1:0] bck_pipe;
        logic [STAGES-1:0] ws_pipe;
        logic              bck_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  bck_now;

    always_comb begin
        bck_now          = sync_q.bck_pipe[STAGES-1];
        sync_d           = sync_q;
        sync_d.bck_pipe  = STAGES'({sync_q.bck_pipe, bck_i});
        sync_d.ws_pipe   = STAGES'({sync_q.ws_pipe, ws_i});
        sync_d.bck_prev  = bck_now;
        launch_o         = edge_sel_i ? (bck_now & ~sync_q.bck_prev)
                                      : (~bck_now & sync_q.bck_prev);
        ws_o             = sync_q.ws_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/audio_ser_tx_slot.sv
module audio_ser_tx_slot #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             ws_i,
    input  logic             i2s_i,
    output logic             step_o,
    output logic [POS_W-1:0] pos_o,
    output logic             left_o,
    output logic             start_o,
    output logic             locked_o
);

    typedef struct packed {
        logic             step;
        logic             start;
        logic             seen;
        logic             locked;
        logic             ws;
        logic             left;
        logic [POS_W-1:0] pos;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  ws_is_left;

    always_comb begin
        ws_is_left   = i2s_i ? ~ws_i : ws_i;
        slot_d       = slot_q;
        slot_d.step  = launch_i;
        slot_d.start = 1'b0;
        if (launch_i) begin
            slot_d.seen = 1'b1;
            slot_d.ws   = ws_i;
            slot_d.left = ws_is_left;
            if (slot_q.seen && (ws_i != slot_q.ws)) begin
                slot_d.locked = 1'b1;
                slot_d.pos    = '0;
                slot_d.start  = ws_is_left;
            end else if (slot_q.pos != {POS_W{1'b1}}) begin
                slot_d.pos = slot_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign step_o   = slot_q.step;
    assign pos_o    = slot_q.pos;
    assign left_o   = slot_q.left;
    assign start_o  = slot_q.start;
    assign locked_o = slot_q.locked;

endmodule

// File: rtl/audio_ser_tx_pick.sv
module audio_ser_tx_pick
    import audio_ser_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int SHORT_W     = 16,
    parameter int NARROW_SLOT = 16,
    parameter int WIDE_SLOT   = 32,
    parameter int POS_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic [POS_W-1:0]    pos_i,
    input  logic                chan_left_i,
    input  logic                start_i,
    input  logic                locked_i,
    input  fmt_dec_t            dec_i,
    input  logic [SAMPLE_W-1:0] left_smp_i,
    input  logic [SAMPLE_W-1:0] right_smp_i,
    output logic                sd_o,
    output logic                err_o
);

    localparam int TRIM  = SAMPLE_W - SHORT_W;
    localparam int IDX_W = $clog2(SAMPLE_W);

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic                carry;
        logic                sd;
        logic                err;
    } pick_t;

    pick_t               pick_d, pick_q;
    logic [SAMPLE_W-1:0] cur_smp;
    logic [SAMPLE_W-1:0] aligned;
    logic                in_word;
    int                  word_len;
    int                  slot_len;
    int                  p;
    int                  bit_idx;

    always_comb begin
        pick_d     = pick_q;
        pick_d.err = ~dec_i.valid;
        if (step_i && start_i) begin
            pick_d.hold_l = left_smp_i;
            pick_d.hold_r = right_smp_i;
        end
        cur_smp  = chan_left_i ? pick_d.hold_l : pick_d.hold_r;
        aligned  = dec_i.long_word ? cur_smp : (cur_smp >> TRIM);
        word_len = dec_i.long_word ? SAMPLE_W : SHORT_W;
        slot_len = dec_i.wide_slot ? WIDE_SLOT : NARROW_SLOT;
        p        = int'(pos_i);
        in_word  = 1'b0;
        bit_idx  = 0;
        if (dec_i.i2s) begin
            if (p >= 1 && p <= word_len) begin
                in_word = 1'b1;
                bit_idx = word_len - p;
            end
        end else if (p >= slot_len - word_len && p < slot_len) begin
            in_word = 1'b1;
            bit_idx = slot_len - 1 - p;
        end
        if (step_i) begin
            if (!dec_i.valid || !locked_i) begin
                pick_d.sd = 1'b0;
            end else if (in_word) begin
                pick_d.sd = aligned[bit_idx[IDX_W-1:0]];
            end else if (dec_i.i2s && p == 0 && word_len == slot_len) begin
                pick_d.sd = pick_q.carry;
            end else begin
                pick_d.sd = 1'b0;
            end
            pick_d.carry = aligned[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pick_q <= '0;
        else        pick_q <= pick_d;
    end

    assign sd_o  = pick_q.sd;
    assign err_o = pick_q.err;

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import audio_ser_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 18,
    parameter int SHORT_W     = 16,
    parameter int NARROW_SLOT = 16,
    parameter int WIDE_SLOT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_i,
    input  logic                edge_sel_i,
    input  logic                en_i,
    input  logic                bck_i,
    input  logic                ws_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                ovl_i,
    output logic                sd_o,
    output logic                ovl_n_o,
    output logic                fmt_err_o
);

    localparam int POS_W = $clog2(WIDE_SLOT) + 1;

    typedef struct packed {
        logic ovl_n;
    } top_t;

    top_t             top_d, top_q;
    fmt_dec_t         dec_w;
    logic             launch_w;
    logic             ws_sync_w;
    logic             step_w;
    logic [POS_W-1:0] pos_w;
    logic             chan_left_w;
    logic             start_w;
    logic             locked_w;
    logic             sd_w;

    always_comb begin
        dec_w       = decode_fmt(fmt_i);
        top_d       = top_q;
        top_d.ovl_n = ~ovl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{ovl_n: 1'b1};
        else        top_q <= top_d;
    end

    audio_ser_tx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_i      (bck_i),
        .ws_i       (ws_i),
        .edge_sel_i (edge_sel_i),
        .launch_o   (launch_w),
        .ws_o       (ws_sync_w)
    );

    audio_ser_tx_slot #(
        .POS_W (POS_W)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch_w),
        .ws_i     (ws_sync_w),
        .i2s_i    (dec_w.i2s),
        .step_o   (step_w),
        .pos_o    (pos_w),
        .left_o   (chan_left_w),
        .start_o  (start_w),
        .locked_o (locked_w)
    );

    audio_ser_tx_pick #(
        .SAMPLE_W    (SAMPLE_W),
        .SHORT_W     (SHORT_W),
        .NARROW_SLOT (NARROW_SLOT),
        .WIDE_SLOT   (WIDE_SLOT),
        .POS_W       (POS_W)
    ) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_w),
        .pos_i       (pos_w),
        .chan_left_i (chan_left_w),
        .start_i     (start_w),
        .locked_i    (locked_w),
        .dec_i       (dec_w),
        .left_smp_i  (left_i),
        .right_smp_i (right_i),
        .sd_o        (sd_w),
        .err_o       (fmt_err_o)
    );

    assign sd_o    = en_i ? sd_w : 1'bz;
    assign ovl_n_o = top_q.ovl_n;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
    parameter int POS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       fmt_i,
    input logic             ovl_i,
    input logic             ovl_n_o,
    input logic             fmt_err_o,
    input logic             launch_w,
    input logic             step_w,
    input logic             sd_w,
    input logic             locked_w,
    input logic [POS_W-1:0] pos_w
);

    // R9
    fmt_flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i[1:0] == 2'b10) |=> fmt_err_o);

    // R9
    fmt_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w && fmt_i[1:0] == 2'b10) |=> !sd_w);

    // R6
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_w |=> $stable(sd_w));

    // R1
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_w |=> $stable(pos_w));

    // R10
    ovl_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_i |=> !ovl_n_o);

    // R10
    ovl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_i |=> ovl_n_o);

    // R11
    unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_w |-> !sd_w);

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_i     (fmt_i),
    .ovl_i     (ovl_i),
    .ovl_n_o   (ovl_n_o),
    .fmt_err_o (fmt_err_o),
    .launch_w  (launch_w),
    .step_w    (step_w),
    .sd_w      (sd_w),
    .locked_w  (locked_w),
    .pos_w     (pos_w)
);

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int SW         = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    fmt_r = 3'b000;
    logic          edge_r = 1'b0;
    logic          en_r = 1'b1;
    logic          bck_r = 1'b1;
    logic          ws_r = 1'b0;
    logic [SW-1:0] left_r = '0;
    logic [SW-1:0] right_r = '0;
    logic          ovl_r = 1'b0;
    logic          sd_o_w;
    logic          ovl_n_w;
    logic          err_w;
    int            n_tests = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_ser_tx i_audio_ser_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt_r),
        .edge_sel_i (edge_r),
        .en_i       (en_r),
        .bck_i      (bck_r),
        .ws_i       (ws_r),
        .left_i     (left_r),
        .right_i    (right_r),
        .ovl_i      (ovl_r),
        .sd_o       (sd_o_w),
        .ovl_n_o    (ovl_n_w),
        .fmt_err_o  (err_w)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [SW-1:0] gen(input int f, input int salt);
        if (f == 0) return (salt == 1) ? 18'h3FFFF : 18'h20001;
        return SW'((f * 93187 + salt * 40503) ^ 18'h2C6D5);
    endfunction

    function automatic logic model(input bit i2s, input int w, input int h,
                                   input int p, input logic [SW-1:0] smp, input logic prev);
        logic [SW-1:0] a;
        a = (w == 18) ? smp : (smp >> 2);
        if (!i2s) begin
            if (p >= h - w && p < h) return a[h - 1 - p];
            return 1'b0;
        end
        if (p >= 1 && p <= w) return a[w - p];
        if (p == 0 && w == h) return prev;
        return 1'b0;
    endfunction

    task automatic do_reset(input logic [2:0] fmt, input logic es);
        @(negedge clk);
        rst_n   = 1'b0;
        fmt_r   = fmt;
        edge_r  = es;
        bck_r   = es ? 1'b0 : 1'b1;
        ws_r    = fmt[2];
        en_r    = 1'b1;
        left_r  = '0;
        right_r = '0;
        ovl_r   = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(3);
    endtask

    task automatic one_period(input logic wsv, input logic exp, input string tag);
        bck_r = edge_r ? 1'b1 : 1'b0;
        ws_r  = wsv;
        wait_neg(HALF - 1);
        check(sd_o_w, exp, tag);
        wait_neg(1);
        bck_r = ~bck_r;
        wait_neg(HALF - 1);
        check(sd_o_w, exp, tag);
        wait_neg(1);
    endtask

    task automatic run_mode(input logic [2:0] fmt, input logic es);
        bit            i2s;
        int            w;
        int            h;
        logic          lv;
        logic          rv;
        logic          prev;
        logic          exp;
        logic [SW-1:0] smp;
        string         tag;
        do_reset(fmt, es);
        i2s = fmt[2];
        w   = (fmt[1:0] == 2'b11) ? 18 : 16;
        h   = (fmt[1:0] == 2'b00) ? 16 : 32;
        lv  = ~fmt[2];
        rv  = fmt[2];
        tag = $sformatf("%s R3 R4 R5 R6 R8 fmt=%b edge=%0d", i2s ? "R2" : "R1", fmt, es);
        left_r  = gen(0, 1);
        right_r = gen(0, 2);
        one_period(rv, 1'b0, "R11 before first word select change");
        one_period(rv, 1'b0, "R11 before first word select change");
        prev = 1'b0;
        for (int f = 0; f < 3; f++) begin
            for (int s = 0; s < 2; s++) begin
                smp = (s == 0) ? gen(f, 1) : gen(f, 2);
                for (int p = 0; p < h; p++) begin
                    if (s == 0 && p == 3) begin
                        left_r  = ~gen(f, 1);
                        right_r = ~gen(f, 2) ^ 18'h00F0F;
                    end
                    if (s == 1 && p == h - 1) begin
                        left_r  = gen(f + 1, 1);
                        right_r = gen(f + 1, 2);
                    end
                    en_r = (f == 1 && s == 1) ? 1'b0 : 1'b1;
                    exp  = model(i2s, w, h, p, smp, prev);
                    if (!en_r) one_period((s == 0) ? lv : rv, 1'bz, "R7 output disabled");
                    else       one_period((s == 0) ? lv : rv, exp, tag);
                end
                prev = (w == 18) ? smp[0] : smp[2];
            end
        end
        en_r = 1'b1;
        one_period(lv, model(i2s, w, h, 0, gen(3, 1), prev), tag);
    endtask

    task automatic run_bad(input logic [2:0] fmt);
        do_reset(fmt, 1'b0);
        wait_neg(2);
        check(err_w, 1'b1, "R9 flag raised for unsupported code");
        left_r  = 18'h2AAAB;
        right_r = 18'h15555;
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 32; p++) begin
                    one_period((s == 0) ? ~fmt[2] : fmt[2], 1'b0, "R9 data held at zero");
                end
            end
        end
        fmt_r = {fmt[2], 2'b01};
        wait_neg(2);
        check(err_w, 1'b0, "R9 flag clears for valid code");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: all requirements, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wait_neg(2);
        check(sd_o_w, 1'b0, "R12 data in reset");
        check(err_w, 1'b0, "R12 error flag in reset");
        check(ovl_n_w, 1'b1, "R12 overload output in reset");
        do_reset(3'b001, 1'b0);
        ovl_r = 1'b1;
        wait_neg(2);
        check(ovl_n_w, 1'b0, "R10 overload asserted");
        ovl_r = 1'b0;
        wait_neg(2);
        check(ovl_n_w, 1'b1, "R10 overload released");
        for (int es = 0; es < 2; es++) begin
            for (int code = 0; code < 8; code++) begin
                if (code[1:0] != 2'b10) run_mode(3'(code), 1'(es));
            end
        end
        run_bad(3'b010);
        run_bad(3'b110);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule